// File: doc/BRIEF.md
# Security-Aware Exception Vector Control

This block keeps the exception-control state of a core that runs in two security worlds and also has a separate monitor mode. It holds three vector base registers: one for the non-secure world, one for the secure world and one for monitor mode. When an exception is taken, it produces a registered vector fetch address. The table is chosen from the monitor-routing flag and the current security state, and the slot within that table is chosen from the exception type.

The block also guards the writes to the status register's interrupt and abort mask bits. A lock register that only secure transactions can reach decides whether non-secure software may change the fast-interrupt mask bit and the external-abort mask bit. The normal interrupt mask bit can always be written. A strap input chooses where the secure table sits after reset.

Top module: `sec_exc_ctrl`

## Requirements
- R1: While `rst` is high, the secure base is loaded as 0xFFFF0000 if `hivec_strap` is 1 and as 0x00000000 if it is 0.
- R2: Reset clears the non-secure base, the monitor base and both lock bits to zero, and sets `psr_mask` to 3'b111.
- R3: Register select 0 is the non-secure base, 1 is the secure base and 2 is the monitor base. Each can be written by either world. A read returns the written value with bits [4:0] forced to zero. Read data appears on `reg_rdata` on the clock edge after `reg_rd_en`.
- R4: Register select 3 is the lock register: bit 0 locks the F bit and bit 1 locks the A bit, and all other bits read as zero. Non-secure writes to it are ignored, and non-secure reads of it return zero.
- R5: The vector table is the monitor base when `exc_to_mon` is 1. Otherwise it is the secure base when `exc_ns` is 0 and the non-secure base when `exc_ns` is 1.
- R6: The vector address is the selected base plus a slot offset taken from `exc_type`: 0→0x00, 1→0x04, 2→0x08, 3→0x0C, 4→0x10, 5→0x18, 6→0x1C, 7→0x14.
- R7: `vec_valid` is high in exactly the cycle after a cycle with `exc_valid` high, and `vec_addr` changes only after such a cycle.
- R8: `psr_mask` bit 0 is I, bit 1 is F and bit 2 is A. A non-secure status write leaves F unchanged when lock bit 0 is set, and leaves A unchanged when lock bit 1 is set.
- R9: Every status write loads the I bit, whatever the world and the lock bits.
- R10: A secure status write (`psr_wr_ns` = 0) loads all three mask bits, whatever the lock bits.
- R11: `psr_mask` changes only on the clock edge after `psr_wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hivec_strap | input | 1 | Chooses the reset location of the secure table |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_ns | input | 1 | Non-secure attribute of the register access |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_type | input | 3 | Exception type code |
| exc_ns | input | 1 | Core is in the non-secure state |
| exc_to_mon | input | 1 | Exception is routed to monitor mode |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 32 | Vector fetch address |
| psr_wr_en | input | 1 | Status mask write strobe |
| psr_wr_ns | input | 1 | Status write issued from the non-secure world |
| psr_wdata | input | 3 | New mask bits {A, F, I} |
| psr_mask | output | 3 | Current mask bits {A, F, I} |

## Verification
The hardest situation to reach from the ports is a non-secure status write that tries to flip a locked bit. To make the attempt visible, the bench first sets every mask bit to the inverse of the value it will try to write, using a secure write. It then issues the non-secure write. It sweeps all four lock settings, both worlds and all eight data values in this way, so that every bit's hold-or-load decision is seen against a real change. The vector path is swept over all type, world and routing combinations, using three distinct, aligned bases.

// File: rtl/sec_exc_pkg.sv
package sec_exc_pkg;
  typedef enum logic [1:0] {
    SEL_NRM_BASE = 2'd0,
    SEL_SEC_BASE = 2'd1,
    SEL_MON_BASE = 2'd2,
    SEL_LOCK     = 2'd3
  } reg_sel_e;

  localparam int unsigned SLOT_W = 5;

  // byte offset of each exception slot inside a table
  function automatic logic [SLOT_W-1:0] slot_offset(input logic [2:0] kind);
    logic [SLOT_W-1:0] off;
    case (kind)
      3'd5:    off = 5'h18;
      3'd6:    off = 5'h1C;
      3'd7:    off = 5'h14;
      default: off = {kind, 2'b00};
    endcase
    return off;
  endfunction
endpackage

// File: rtl/vec_base_bank.sv
module vec_base_bank #(
  parameter int unsigned AW         = 32,
  parameter int unsigned ALIGN      = 5,
  parameter logic [AW-1:0] HI_BASE  = 32'hFFFF0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hivec_strap,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] nrm_base,
  output logic [AW-1:0] sec_base,
  output logic [AW-1:0] mon_base
);
  localparam int unsigned NBANK = 3;
  localparam int unsigned HW    = AW - ALIGN;

  logic [HW-1:0] base_q [NBANK];

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        if (gi == 1)
          base_q[gi] <= hivec_strap ? HI_BASE[AW-1:ALIGN] : '0;
        else
          base_q[gi] <= '0;
      end else if (wr_en && wr_sel == 2'(gi)) begin
        base_q[gi] <= wdata[AW-1:ALIGN];
      end
    end
  end

  assign nrm_base = {base_q[0], {ALIGN{1'b0}}};
  assign sec_base = {base_q[1], {ALIGN{1'b0}}};
  assign mon_base = {base_q[2], {ALIGN{1'b0}}};
endmodule

// File: rtl/psr_guard.sv
module psr_guard #(
  parameter int unsigned LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_wr_en,
  input  logic [LOCK_W-1:0] lock_wdata,
  input  logic              psr_wr_en,
  input  logic              psr_wr_ns,
  input  logic [LOCK_W:0]   psr_wdata,
  output logic [LOCK_W-1:0] lock_q,
  output logic [LOCK_W:0]   psr_q
);
  logic [LOCK_W:0] psr_nxt;

  always_ff @(posedge clk) begin
    if (rst)             lock_q <= '0;
    else if (lock_wr_en) lock_q <= lock_wdata;
  end

  // bit 0 (I) is never guarded; bit k+1 is guarded by lock bit k
  always_comb begin
    psr_nxt[0] = psr_wdata[0];
    for (int k = 0; k < LOCK_W; k++)
      psr_nxt[k+1] = (psr_wr_ns && lock_q[k]) ? psr_q[k+1] : psr_wdata[k+1];
  end

  always_ff @(posedge clk) begin
    if (rst)            psr_q <= '1;
    else if (psr_wr_en) psr_q <= psr_nxt;
  end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import sec_exc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nrm_base,
  input  logic [AW-1:0] sec_base,
  input  logic [AW-1:0] mon_base,
  input  logic          exc_valid,
  input  logic [2:0]    exc_type,
  input  logic          exc_ns,
  input  logic          exc_to_mon,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr
);
  logic [AW-1:0] table_base;

  always_comb begin
    if (exc_to_mon)  table_base = mon_base;
    else if (exc_ns) table_base = nrm_base;
    else             table_base = sec_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= exc_valid;
      if (exc_valid)
        vec_addr <= table_base + AW'(slot_offset(exc_type));
    end
  end
endmodule

// File: rtl/sec_exc_ctrl.sv
module sec_exc_ctrl
  import sec_exc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned ALIGN  = 5,
  parameter int unsigned LOCK_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hivec_strap,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic          reg_ns,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          exc_valid,
  input  logic [2:0]    exc_type,
  input  logic          exc_ns,
  input  logic          exc_to_mon,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  input  logic          psr_wr_en,
  input  logic          psr_wr_ns,
  input  logic [2:0]    psr_wdata,
  output logic [2:0]    psr_mask
);
  logic [AW-1:0]     nrm_base, sec_base, mon_base;
  logic [LOCK_W-1:0] prot_lock;
  logic              base_wr, lock_wr;

  assign base_wr = reg_wr_en && (reg_sel != SEL_LOCK);
  assign lock_wr = reg_wr_en && (reg_sel == SEL_LOCK) && !reg_ns;

  vec_base_bank #(.AW(AW), .ALIGN(ALIGN)) i_bank (
    .clk, .rst, .hivec_strap,
    .wr_en(base_wr), .wr_sel(reg_sel), .wdata(reg_wdata),
    .nrm_base, .sec_base, .mon_base
  );

  psr_guard #(.LOCK_W(LOCK_W)) i_guard (
    .clk, .rst,
    .lock_wr_en(lock_wr), .lock_wdata(reg_wdata[LOCK_W-1:0]),
    .psr_wr_en, .psr_wr_ns, .psr_wdata,
    .lock_q(prot_lock), .psr_q(psr_mask)
  );

  vec_addr_gen #(.AW(AW)) i_vec (
    .clk, .rst, .nrm_base, .sec_base, .mon_base,
    .exc_valid, .exc_type, .exc_ns, .exc_to_mon,
    .vec_valid, .vec_addr
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      case (reg_sel)
        SEL_NRM_BASE: reg_rdata <= nrm_base;
        SEL_SEC_BASE: reg_rdata <= sec_base;
        SEL_MON_BASE: reg_rdata <= mon_base;
        default:      reg_rdata <= reg_ns ? '0 : AW'(prot_lock);
      endcase
    end
  end
endmodule

// File: rtl/sec_exc_ctrl_chk.sv
module sec_exc_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic        reg_ns,
  input logic [1:0]  reg_sel,
  input logic        exc_valid,
  input logic        vec_valid,
  input logic [31:0] vec_addr,
  input logic        psr_wr_en,
  input logic        psr_wr_ns,
  input logic [2:0]  psr_wdata,
  input logic [2:0]  psr_mask,
  input logic [1:0]  prot_lock
);
  // R7
  vec_follows_exc_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> vec_valid);
  // R7
  no_spurious_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |=> !vec_valid && $stable(vec_addr));
  // R6
  vec_word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec_addr[1:0] == 2'b00);
  // R9
  irq_bit_always_chk: assert property (@(posedge clk) disable iff (rst)
    psr_wr_en |=> psr_mask[0] == $past(psr_wdata[0]));
  // R8
  fiq_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    psr_wr_en && psr_wr_ns && prot_lock[0] |=> $stable(psr_mask[1]));
  // R8
  abt_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    psr_wr_en && psr_wr_ns && prot_lock[1] |=> $stable(psr_mask[2]));
  // R10
  secure_psr_write_chk: assert property (@(posedge clk) disable iff (rst)
    psr_wr_en && !psr_wr_ns |=> psr_mask == $past(psr_wdata));
  // R11
  psr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !psr_wr_en |=> $stable(psr_mask));
  // R4
  ns_lock_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en && reg_ns && reg_sel == 2'd3 |=> $stable(prot_lock));
endmodule

bind sec_exc_ctrl sec_exc_ctrl_chk i_chk (
  .clk, .rst, .reg_wr_en, .reg_ns, .reg_sel, .exc_valid,
  .vec_valid, .vec_addr, .psr_wr_en, .psr_wr_ns, .psr_wdata,
  .psr_mask, .prot_lock
);

// File: tb/test_sec_exc_ctrl.sv
module test_sec_exc_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, hivec_strap;
  logic        reg_wr_en, reg_rd_en, reg_ns;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        exc_valid, exc_ns, exc_to_mon;
  logic [2:0]  exc_type;
  logic        vec_valid;
  logic [31:0] vec_addr;
  logic        psr_wr_en, psr_wr_ns;
  logic [2:0]  psr_wdata, psr_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sec_exc_ctrl i_sec_exc_ctrl (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d, input logic ns);
    @(negedge clk);
    reg_wr_en = 1; reg_sel = sel; reg_wdata = d; reg_ns = ns;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic reg_read(input logic [1:0] sel, input logic ns, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_sel = sel; reg_ns = ns;
    @(negedge clk);
    d = reg_rdata;
    reg_rd_en = 0;
  endtask

  task automatic psr_write(input logic [2:0] d, input logic ns);
    @(negedge clk);
    psr_wr_en = 1; psr_wdata = d; psr_wr_ns = ns;
    @(negedge clk);
    psr_wr_en = 0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1; hivec_strap = strap;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  function automatic logic [31:0] exp_off(input logic [2:0] t);
    case (t)
      3'd5: return 32'h18;
      3'd6: return 32'h1C;
      3'd7: return 32'h14;
      default: return 32'(t) * 4;
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, base_n, base_s, base_m, exp;
    logic [2:0]  pexp;
    logic [31:0] pats [3];
    rst = 1; hivec_strap = 1;
    reg_wr_en = 0; reg_rd_en = 0; reg_ns = 0; reg_sel = 0; reg_wdata = 0;
    exc_valid = 0; exc_type = 0; exc_ns = 0; exc_to_mon = 0;
    psr_wr_en = 0; psr_wr_ns = 0; psr_wdata = 0;

    // R1 R2: reset state with strap high
    do_reset(1'b1);
    check(psr_mask == 3'b111, "R2 psr reset", 32'(psr_mask), 32'h7);
    check(vec_valid == 1'b0, "R7 vec_valid reset", 32'(vec_valid), 0);
    reg_read(2'd1, 1'b0, rd); check(rd == 32'hFFFF0000, "R1 secure base strap=1", rd, 32'hFFFF0000);
    reg_read(2'd0, 1'b0, rd); check(rd == 0, "R2 normal base reset", rd, 0);
    reg_read(2'd2, 1'b0, rd); check(rd == 0, "R2 monitor base reset", rd, 0);
    reg_read(2'd3, 1'b0, rd); check(rd == 0, "R2 lock reset", rd, 0);
    // R1 strap low
    do_reset(1'b0);
    reg_read(2'd1, 1'b0, rd); check(rd == 0, "R1 secure base strap=0", rd, 0);

    // R3: base register sweep, both worlds
    pats[0] = 32'hFFFFFFFF; pats[1] = 32'h12345678; pats[2] = 32'hA5A5A5BF;
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 3; p++)
        for (int w = 0; w < 2; w++) begin
          reg_write(2'(s), pats[p] ^ 32'(w * 32'h0F0F0000), 1'(w));
          reg_read(2'(s), 1'(1 - w), rd);
          exp = (pats[p] ^ 32'(w * 32'h0F0F0000)) & ~32'h1F;
          check(rd == exp, "R3 base readback", rd, exp);
        end

    // R4: lock register access rules
    reg_write(2'd3, 32'hFFFFFFFF, 1'b1);
    reg_read(2'd3, 1'b0, rd); check(rd == 0, "R4 ns write ignored", rd, 0);
    reg_write(2'd3, 32'hFFFFFFFF, 1'b0);
    reg_read(2'd3, 1'b0, rd); check(rd == 32'h3, "R4 secure readback", rd, 32'h3);
    reg_read(2'd3, 1'b1, rd); check(rd == 0, "R4 ns read zero", rd, 0);
    reg_write(2'd3, 32'h0, 1'b1);
    reg_read(2'd3, 1'b0, rd); check(rd == 32'h3, "R4 ns clear ignored", rd, 32'h3);

    // R5 R6 R7: vector sweep
    base_n = 32'h10000000; base_s = 32'h20000040; base_m = 32'h30000080;
    reg_write(2'd0, base_n, 1'b1);
    reg_write(2'd1, base_s, 1'b0);
    reg_write(2'd2, base_m, 1'b0);
    for (int t = 0; t < 8; t++)
      for (int ns = 0; ns < 2; ns++)
        for (int m = 0; m < 2; m++) begin
          @(negedge clk);
          exc_valid = 1; exc_type = 3'(t); exc_ns = 1'(ns); exc_to_mon = 1'(m);
          @(negedge clk);
          exc_valid = 0;
          exp = (m ? base_m : (ns ? base_n : base_s)) + exp_off(3'(t));
          check(vec_valid == 1'b1, "R7 vec_valid asserted", 32'(vec_valid), 1);
          check(vec_addr == exp, "R5 R6 vector address", vec_addr, exp);
          @(negedge clk);
          check(vec_valid == 1'b0, "R7 vec_valid single", 32'(vec_valid), 0);
          check(vec_addr == exp, "R7 vec_addr held", vec_addr, exp);
        end

    // R8 R9 R10: status mask guard sweep
    for (int lk = 0; lk < 4; lk++) begin
      reg_write(2'd3, 32'(lk), 1'b0);
      for (int ns = 0; ns < 2; ns++)
        for (int d = 0; d < 8; d++) begin
          psr_write(~3'(d), 1'b0);
          check(psr_mask == ~3'(d), "R10 secure write all bits", 32'(psr_mask), 32'(~3'(d)));
          psr_write(3'(d), 1'(ns));
          pexp[0] = 1'(d);
          pexp[1] = (ns && lk[0]) ? ~d[1] : d[1];
          pexp[2] = (ns && lk[1]) ? ~d[2] : d[2];
          check(psr_mask == pexp, ns ? "R8 R9 ns write guard" : "R10 R9 secure write",
                32'(psr_mask), 32'(pexp));
          // R11: no change without a write strobe
          @(negedge clk);
          psr_wdata = ~psr_mask; psr_wr_ns = 0;
          @(negedge clk);
          check(psr_mask == pexp, "R11 psr hold", 32'(psr_mask), 32'(pexp));
        end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule